// File: doc/BRIEF.md
# Round constant generator

This block supplies the per-round constant of the Keccak-f permutation. It keeps no table of constants. An 8-bit linear feedback shift register is stepped seven times per round. The seven output bits land at the word positions 0, 1, 3, 7, 15, 31 and 63, which are the positions of the form 2^j−1. Every other bit of the word is zero. The word is then cut to the lane width that the parameter selects.

A start pulse reloads the shift register with its seed and produces the round-0 constant. Each advance strobe produces the constant of the next round. The register keeps running across rounds, so round r uses feedback steps 7r to 7r+6. The round count is 12 + 2·log2(LANE_W). A done flag rises together with the constant of the last round. The permutation datapath samples the outputs on the cycle after each strobe.

Top module: `rc_round_gen`

## Requirements
- R1: While reset is asserted and right after it, round_o is 0, const_o is all zeros and done_o is 0.
- R2: Before the first start pulse after reset, advance strobes are ignored: round_o, const_o and done_o keep their reset values.
- R3: One cycle after start_i, round_o is 0, done_o is 0 and const_o holds the round-0 constant, which is 1 in bit 0 and zero elsewhere.
- R4: The shift register is bits S[0..7] with seed S[0]=1 and all others 0. One step shifts every bit up one place and feeds 0 into S[0]. If the bit shifted out of S[7] is 1, S[0], S[4], S[5] and S[6] are inverted. rc(t) is S[0] after t steps. For round r, bit 2^j−1 of the 64-bit constant equals rc(7r+j) for j = 0..6.
- R5: Every bit of the constant not at a position 2^j−1 is zero.
- R6: const_o is the low LANE_W bits of the 64-bit constant. Constant bits at positions of LANE_W and above are dropped.
- R7: An accepted advance strobe raises round_o by one. On the next cycle const_o holds that round's constant.
- R8: The round count is 12 + 2·log2(LANE_W). done_o rises in the same cycle that round_o reaches the last round, count−1, and const_o holds that round's constant.
- R9: While done_o is 1, advance strobes change none of the outputs.
- R10: A start pulse restarts from round 0 at any point, including mid-sequence and after done. Start takes priority over an advance strobe in the same cycle.
- R11: At LANE_W = 64 the constants of rounds 0, 1, 2 and 23 are 0x0000000000000001, 0x0000000000008082, 0x800000000000808A and 0x8000000080008008.
- R12: In a cycle with neither strobe, all outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reload the seed and produce the round-0 constant |
| advance_i | input | 1 | Produce the constant of the next round |
| round_o | output | $clog2(12+2·log2(LANE_W)), 5 at default | Index of the round whose constant is on const_o |
| const_o | output | LANE_W | Round constant, cut to the lane width |
| done_o | output | 1 | Constant of the last round is on const_o |

## Verification
The bench builds three copies side by side from the same strobes, at LANE_W of 64, 8 and 1. The 64-bit lane reaches all 24 rounds and the published constants. The 8-bit lane drops the upper constant bits and finishes after 18 rounds. The 1-bit lane keeps only bit 0 and finishes after 12 rounds. Because the lanes finish at different times, the bench sees the narrow lanes ignore strobes while the wide lane still advances, and sees a restart reach lanes that are in different states.

// File: rtl/rcgen_pkg.sv
package rcgen_pkg;

  localparam int LFSR_W     = 8;
  localparam int BITS_PER_RND = 7;
  localparam int FULL_LANE  = 64;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // Only S[0] set after a reload
  localparam lfsr_t LFSR_SEED = 8'h01;

  // One feedback step: shift toward the top, fold the bit that drops out
  // back into taps 0, 4, 5 and 6.
  function automatic lfsr_t lfsr_step(lfsr_t s);
    lfsr_t n;
    logic  fb;
    fb = s[LFSR_W-1];
    n  = {s[LFSR_W-2:0], 1'b0};
    n[0] = n[0] ^ fb;
    n[4] = n[4] ^ fb;
    n[5] = n[5] ^ fb;
    n[6] = n[6] ^ fb;
    return n;
  endfunction

  // Which constant bit index j lands on word position k (k = 2^j - 1), or -1
  function automatic int slot_of_pos(int k);
    int r;
    r = -1;
    for (int j = 0; j < BITS_PER_RND; j++) begin
      if (k == (1 << j) - 1) r = j;
    end
    return r;
  endfunction

endpackage

// File: rtl/rc_lfsr_cascade.sv
module rc_lfsr_cascade
  import rcgen_pkg::*;
#(
  parameter int STEPS = BITS_PER_RND
) (
  input  lfsr_t             state_i,
  output lfsr_t             state_o,
  output logic [STEPS-1:0]  bits_o
);

  lfsr_t chain [STEPS+1];

  assign chain[0] = state_i;

  for (genvar j = 0; j < STEPS; j++) begin : g_step
    // bit j of the round is the register output before step j
    assign bits_o[j]    = chain[j][0];
    assign chain[j+1]   = lfsr_step(chain[j]);
  end

  assign state_o = chain[STEPS];

endmodule

// File: rtl/rc_bit_placer.sv
module rc_bit_placer
  import rcgen_pkg::*;
#(
  parameter int LANE_W = FULL_LANE,
  parameter int NBITS  = BITS_PER_RND
) (
  input  logic [NBITS-1:0]  bits_i,
  output logic [LANE_W-1:0] word_o
);

  for (genvar k = 0; k < LANE_W; k++) begin : g_pos
    localparam int SLOT = slot_of_pos(k);
    if (SLOT >= 0 && SLOT < NBITS) begin : g_live
      assign word_o[k] = bits_i[SLOT];
    end else begin : g_zero
      assign word_o[k] = 1'b0;
    end
  end

  // Slots above the lane are dropped on narrow lanes
  logic unused_bits;
  assign unused_bits = ^bits_i;

endmodule

// File: rtl/rc_round_gen.sv
module rc_round_gen
  import rcgen_pkg::*;
#(
  parameter int LANE_W = 64,
  localparam int LOG_W      = $clog2(LANE_W),
  localparam int NUM_ROUNDS = 12 + 2 * LOG_W,
  localparam int RND_W      = $clog2(NUM_ROUNDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              advance_i,
  output logic [RND_W-1:0]  round_o,
  output logic [LANE_W-1:0] const_o,
  output logic              done_o
);

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);
  localparam logic [RND_W-1:0] PRE_LAST = RND_W'(NUM_ROUNDS - 2);

  lfsr_t               lfsr_q, lfsr_d, casc_in, casc_out;
  logic [RND_W-1:0]    round_q, round_d;
  logic [LANE_W-1:0]   const_q, const_d, placed;
  logic                done_q, done_d;
  logic                active_q, active_d;
  logic [BITS_PER_RND-1:0] rnd_bits;
  logic                adv_ok, step_en;

  assign adv_ok  = advance_i & active_q & ~done_q;
  assign step_en = start_i | adv_ok;
  assign casc_in = start_i ? LFSR_SEED : lfsr_q;

  rc_lfsr_cascade #(.STEPS(BITS_PER_RND)) u_cascade (
    .state_i (casc_in),
    .state_o (casc_out),
    .bits_o  (rnd_bits)
  );

  rc_bit_placer #(.LANE_W(LANE_W), .NBITS(BITS_PER_RND)) u_placer (
    .bits_i (rnd_bits),
    .word_o (placed)
  );

  // Next-state
  always_comb begin
    lfsr_d   = lfsr_q;
    round_d  = round_q;
    const_d  = const_q;
    done_d   = done_q;
    active_d = active_q;
    if (start_i) begin
      lfsr_d   = casc_out;
      round_d  = '0;
      const_d  = placed;
      done_d   = 1'b0;
      active_d = 1'b1;
    end else if (adv_ok) begin
      lfsr_d   = casc_out;
      round_d  = round_q + RND_W'(1);
      const_d  = placed;
      done_d   = (round_q == PRE_LAST);
    end
  end

  // Registers, enabled only on an accepted strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q   <= LFSR_SEED;
      round_q  <= '0;
      const_q  <= '0;
      done_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (step_en) begin
      lfsr_q   <= lfsr_d;
      round_q  <= round_d;
      const_q  <= const_d;
      done_q   <= done_d;
      active_q <= active_d;
    end
  end

  assign round_o = round_q;
  assign const_o = const_q;
  assign done_o  = done_q;

  // Assertions
  p_start_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (round_o == '0) && !done_o);

  p_advance_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !start_i && active_q && !done_o) |=>
      (round_o == $past(round_o) + RND_W'(1)));

  p_done_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(round_o) && $stable(const_o));

  p_done_at_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (round_o == LAST_RND));

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> $stable(const_o) && $stable(round_o) && !done_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !advance_i) |=>
      $stable(const_o) && $stable(round_o) && $stable(done_o));

  p_lfsr_live_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (lfsr_q != '0));

  p_round0_const_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (const_o == LANE_W'(1)));

endmodule

// File: tb/tb_rc_round_gen.sv
module tb_rc_round_gen;

  localparam int NLANE = 3;
  localparam int WIDTHS [NLANE] = '{64, 8, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic advance = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // rc(t): S[0] of an 8-bit register after t steps from seed 1
  function automatic bit rc_bit(int t);
    logic [8:0] r;
    r = 9'h001;
    for (int i = 0; i < t % 255; i++) begin
      r = r << 1;
      if (r[8]) r = r ^ 9'h171;
    end
    return r[0];
  endfunction

  function automatic logic [63:0] ref_const(int rnd);
    logic [63:0] c;
    c = '0;
    for (int j = 0; j < 7; j++) c[(1 << j) - 1] = rc_bit(7 * rnd + j);
    return c;
  endfunction

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    localparam int LW = WIDTHS[i];
    localparam int NR = 12 + 2 * $clog2(LW);
    localparam int RW = $clog2(NR);

    logic [RW-1:0] round_w;
    logic [LW-1:0] const_w;
    logic          done_w;

    int m_round;
    bit m_done;
    bit m_active;
    int l_chk;
    int l_fail;

    initial begin
      l_chk = 0;
      l_fail = 0;
      m_round = 0;
      m_done = 0;
      m_active = 0;
    end

    rc_round_gen #(.LANE_W(LW)) dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .advance_i (advance),
      .round_o   (round_w),
      .const_o   (const_w),
      .done_o    (done_w)
    );

    // Behavioural model (R1 R2 R7 R8 R9 R10 R12)
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_round = 0;
        m_done = 0;
        m_active = 0;
      end else if (start) begin
        m_round = 0;
        m_done = 0;
        m_active = 1;
      end else if (advance && m_active && !m_done) begin
        m_round = m_round + 1;
        m_done = (m_round == NR - 1);
      end
    end

    // Per-cycle comparison (R4 R5 R6 R7)
    always @(negedge clk) begin
      logic [63:0] full;
      logic [LW-1:0] exp_c;
      full = m_active ? ref_const(m_round) : 64'd0;
      exp_c = full[LW-1:0];
      l_chk++;
      if (round_w !== RW'(m_round) || const_w !== exp_c || done_w !== m_done) begin
        l_fail++;
        $display("FAIL R4 R7 lane %0d: round %0d const %h done %0b, expected round %0d const %h done %0b",
                 LW, round_w, const_w, done_w, m_round, exp_c, m_done);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    int tot, pass;
    tot = n_chk + g_lane[0].l_chk + g_lane[1].l_chk + g_lane[2].l_chk;
    pass = tot - (n_fail + g_lane[0].l_fail + g_lane[1].l_fail + g_lane[2].l_fail);
    $display("%0d/%0d checks passed", pass, tot);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulse_adv();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [63:0] keep;
    @(negedge clk);
    // R1: during reset
    check(g_lane[0].const_w == 64'd0 && g_lane[0].round_w == 0 && !g_lane[0].done_w,
          "R1 in reset", g_lane[0].const_w, 64'd0);
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    check(g_lane[0].const_w == 64'd0 && !g_lane[0].done_w, "R1 after reset",
          g_lane[0].const_w, 64'd0);

    // R2: advance before start ignored
    pulse_adv();
    pulse_adv();
    check(g_lane[0].const_w == 64'd0 && g_lane[0].round_w == 0, "R2 idle advance",
          {59'd0, g_lane[0].round_w}, 64'd0);

    // R3 / R11 round 0
    pulse_start();
    check(g_lane[0].const_w == 64'h1 && g_lane[0].round_w == 0 && !g_lane[0].done_w,
          "R3 round0", g_lane[0].const_w, 64'h1);
    check(g_lane[2].const_w == 1'b1, "R6 lane1 round0", 64'(g_lane[2].const_w), 64'h1);

    // R7 / R11 round 1
    pulse_adv();
    check(g_lane[0].const_w == 64'h0000000000008082 && g_lane[0].round_w == 1,
          "R11 round1", g_lane[0].const_w, 64'h8082);
    check(g_lane[1].const_w == 8'h82, "R6 lane8 round1", 64'(g_lane[1].const_w), 64'h82);
    check(g_lane[2].const_w == 1'b0, "R6 lane1 round1", 64'(g_lane[2].const_w), 64'h0);

    pulse_adv();
    check(g_lane[0].const_w == 64'h800000000000808A, "R11 round2",
          g_lane[0].const_w, 64'h800000000000808A);
    check((g_lane[0].const_w & ~64'h800000008000808B) == 64'd0, "R5 sparse round2",
          g_lane[0].const_w, 64'd0);

    // R12: hold without strobes
    keep = g_lane[0].const_w;
    idle(4);
    check(g_lane[0].const_w == keep && g_lane[0].round_w == 2, "R12 hold",
          g_lane[0].const_w, keep);

    // Burst of held advance up to round 16
    advance = 1'b1;
    idle(14);
    advance = 1'b0;
    check(g_lane[0].round_w == 16 && !g_lane[1].done_w && g_lane[2].done_w,
          "R8 lane8 not yet done, lane1 done", {59'd0, g_lane[0].round_w}, 64'd16);
    pulse_adv();
    check(g_lane[1].done_w && g_lane[1].round_w == 17, "R8 lane8 done at 17",
          64'(g_lane[1].round_w), 64'd17);
    check(g_lane[2].round_w == 11, "R9 lane1 frozen at 11", 64'(g_lane[2].round_w), 64'd11);

    // Spaced advances to the end of the full lane
    for (int k = 0; k < 6; k++) begin
      pulse_adv();
      idle(1);
    end
    check(g_lane[0].const_w == 64'h8000000080008008 && g_lane[0].done_w
          && g_lane[0].round_w == 23, "R8 R11 round23", g_lane[0].const_w,
          64'h8000000080008008);

    // R9: advances after done
    pulse_adv();
    pulse_adv();
    check(g_lane[0].const_w == 64'h8000000080008008 && g_lane[0].round_w == 23,
          "R9 done ignores advance", g_lane[0].const_w, 64'h8000000080008008);

    // R10: start and advance together
    start = 1'b1;
    advance = 1'b1;
    @(negedge clk);
    start = 1'b0;
    advance = 1'b0;
    check(g_lane[0].const_w == 64'h1 && g_lane[0].round_w == 0 && !g_lane[0].done_w,
          "R10 start wins", g_lane[0].const_w, 64'h1);

    // R10: restart mid sequence
    pulse_adv();
    pulse_adv();
    pulse_adv();
    pulse_start();
    check(g_lane[0].const_w == 64'h1 && g_lane[0].round_w == 0, "R10 mid restart",
          g_lane[0].const_w, 64'h1);
    pulse_adv();
    check(g_lane[0].const_w == 64'h8082, "R4 stream restarts from seed",
          g_lane[0].const_w, 64'h8082);

    idle(2);
    report();
    $finish;
  end

endmodule